// File: doc/BRIEF.md
# Double-Edge Ethernet MAC-to-PHY Bridge with Link Status Decode

This block connects a MAC that moves one byte per clock (or one nibble per clock at the lower rates) to a PHY that moves a nibble on every clock edge. On the transmit side it takes a byte, an enable and an error flag. It puts the two nibbles and a folded control bit onto the reduced-width lines, one set in each half of the clock period. On the receive side it captures the nibble and control bit at both edges. It then rebuilds the byte together with data-valid and error flags. Both edges of the interface clock carry data, so the block needs no second, faster clock.

The same datapath serves gigabit, 100 Mb/s and 10 Mb/s operation. The interface clock runs at 125 MHz, 25 MHz or 2.5 MHz respectively. A `gig_mode` input tells the bridge whether the high nibble is meaningful. At the lower rates the same nibble appears in both half-periods, and the byte-wide MAC side acts as a 4-bit path.

Between frames, the PHY signals its link state on the receive data lines. The bridge decodes it and holds the result on three outputs that the MAC uses for link detection: link up, link speed and full duplex.

Top module: `rgmii_bridge`

## Requirements
- R1: While reset is asserted, the transmit nibble and transmit control lines are low in both clock phases. The received byte, data-valid and error are zero. Link up is 0, link speed is 00 (10 Mb/s) and full duplex is 0.
- R2: With `gig_mode` high, a byte captured at a rising `tx_clk` edge is shown in two halves. In the high phase that follows the edge, the lines carry bits 3:0 and the control line equals the transmit enable. In the next low phase, the lines carry bits 7:4 and the control line equals enable XOR error.
- R3: With `gig_mode` low, both phases carry bits 3:0 of the captured byte. The control line still equals the enable in the high phase and enable XOR error in the low phase.
- R4: With `gig_mode` high, a nibble and control bit captured at a rising `rx_clk` edge are paired with those captured at the following falling edge. At the next rising edge the bridge outputs byte = {falling nibble, rising nibble}, data-valid = rising control, and error = rising control XOR falling control.
- R5: With `gig_mode` low, the received byte carries the rising-edge nibble in bits 3:0, and bits 7:4 are zero. Data-valid and error follow R4.
- R6: When both captured control bits of a pair are low, the rising nibble is decoded as link status at the same edge that outputs the pair. Bit 0 is link up. Bits 2:1 are the speed (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s). Bit 3 is full duplex.
- R7: When either control bit of a pair is high, the link status outputs keep their previous values.
- R8: An idle status nibble whose speed field is 11 is ignored, and all three status outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit interface clock |
| rx_clk | input | 1 | Receive interface clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| gig_mode | input | 1 | 1 = byte per cycle (gigabit), 0 = nibble per cycle |
| mac_txd | input | 8 | Transmit byte from the MAC |
| mac_tx_en | input | 1 | Transmit enable from the MAC |
| mac_tx_er | input | 1 | Transmit error from the MAC |
| rgmii_txd | output | 4 | Double-edge transmit nibble to the PHY |
| rgmii_tx_ctl | output | 1 | Double-edge transmit control to the PHY |
| rgmii_rxd | input | 4 | Double-edge receive nibble from the PHY |
| rgmii_rx_ctl | input | 1 | Double-edge receive control from the PHY |
| mac_rxd | output | 8 | Rebuilt receive byte to the MAC |
| mac_rx_dv | output | 1 | Receive data valid to the MAC |
| mac_rx_er | output | 1 | Receive error to the MAC |
| link_up | output | 1 | Decoded link status |
| link_speed | output | 2 | Decoded speed: 00 = 10, 01 = 100, 10 = 1000 Mb/s |
| full_duplex | output | 1 | Decoded duplex mode |

## Verification
A wrong nibble or control register on the transmit side shows up on the lines within the same clock period: the high or low phase right after the capturing edge carries the wrong value. A bad receive capture or pairing shows up on the rebuilt byte and flags at the next rising edge, one cycle after the falling half is taken. A status register that updates when it should not, or misses an update, is visible on the status outputs at that same edge. It then persists until the next valid idle pair, so the sweep compares all three status outputs after every received pair.

// File: rtl/rgb_pkg.sv
package rgb_pkg;

   typedef enum logic [1:0] {
      SPD_10   = 2'b00,
      SPD_100  = 2'b01,
      SPD_1000 = 2'b10,
      SPD_RSVD = 2'b11
   } spd_e;

   typedef struct packed {
      logic link;
      spd_e speed;
      logic fdx;
   } lnk_stat_t;

   localparam int STAT_LINK_BIT = 0;
   localparam int STAT_SPD_LSB  = 1;
   localparam int STAT_FDX_BIT  = 3;
   localparam int STAT_MIN_W    = 4;

   localparam lnk_stat_t STAT_RESET = '{link: 1'b0, speed: SPD_10, fdx: 1'b0};

endpackage

// File: rtl/rgb_tx_ddr.sv
module rgb_tx_ddr #(
   parameter int NIB_W = 4,
   localparam int BYTE_W = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gig,
   input  logic [BYTE_W-1:0] d,
   input  logic              en,
   input  logic              er,
   output logic [NIB_W-1:0]  q,
   output logic              ctl
);

   logic [NIB_W-1:0] hi_phase_q;
   logic [NIB_W-1:0] lo_phase_q;
   logic             hi_ctl_q;
   logic             lo_ctl_q;
   logic [NIB_W-1:0] lo_sel;

   // Nibble for the second half-period: upper bits at gigabit, repeat otherwise
   assign lo_sel = gig ? d[BYTE_W-1:NIB_W] : d[NIB_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_phase_q <= '0;
         lo_phase_q <= '0;
         hi_ctl_q   <= 1'b0;
         lo_ctl_q   <= 1'b0;
      end else begin
         hi_phase_q <= d[NIB_W-1:0];
         lo_phase_q <= lo_sel;
         hi_ctl_q   <= en;
         lo_ctl_q   <= en ^ er;
      end
   end

   // Behavioural double-edge launch: the clock level picks the half-period
   for (genvar i = 0; i < NIB_W; i++) begin : g_lane
      assign q[i] = clk ? hi_phase_q[i] : lo_phase_q[i];
   end

   assign ctl = clk ? hi_ctl_q : lo_ctl_q;

endmodule

// File: rtl/rgb_rx_ddr.sv
module rgb_rx_ddr #(
   parameter int NIB_W = 4,
   localparam int BYTE_W = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gig,
   input  logic [NIB_W-1:0]  pin_d,
   input  logic              pin_ctl,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_dv,
   output logic              rx_er,
   output logic [NIB_W-1:0]  pair_nib,
   output logic              pair_idle
);

   logic [NIB_W-1:0] rise_d_q;
   logic             rise_c_q;
   logic [NIB_W-1:0] fall_d_q;
   logic             fall_c_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_d_q <= '0;
         rise_c_q <= 1'b0;
      end else begin
         rise_d_q <= pin_d;
         rise_c_q <= pin_ctl;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_d_q <= '0;
         fall_c_q <= 1'b0;
      end else begin
         fall_d_q <= pin_d;
         fall_c_q <= pin_ctl;
      end
   end

   // Pair (rising, following falling) is assembled at the next rising edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte <= '0;
         rx_dv   <= 1'b0;
         rx_er   <= 1'b0;
      end else begin
         rx_byte <= gig ? {fall_d_q, rise_d_q} : {{NIB_W{1'b0}}, rise_d_q};
         rx_dv   <= rise_c_q;
         rx_er   <= rise_c_q ^ fall_c_q;
      end
   end

   assign pair_nib  = rise_d_q;
   assign pair_idle = !rise_c_q && !fall_c_q;

endmodule

// File: rtl/rgb_inband_stat.sv
module rgb_inband_stat
   import rgb_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic [NIB_W-1:0] nib,
   output lnk_stat_t        stat
);

   lnk_stat_t dec;
   logic      dec_ok;

   always_comb begin
      dec.link  = nib[STAT_LINK_BIT];
      dec.speed = spd_e'(nib[STAT_SPD_LSB +: 2]);
      dec.fdx   = nib[STAT_FDX_BIT];
      dec_ok    = idle && (dec.speed != SPD_RSVD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= STAT_RESET;
      end else if (dec_ok) begin
         stat <= dec;
      end
   end

   // Lanes above the status field carry nothing during idle
   if (NIB_W > STAT_MIN_W) begin : g_wide
      logic unused_hi;
      assign unused_hi = ^nib[NIB_W-1:STAT_MIN_W];
   end

endmodule

// File: rtl/rgmii_bridge.sv
module rgmii_bridge
   import rgb_pkg::*;
#(
   parameter int NIB_W = 4,
   localparam int BYTE_W = 2 * NIB_W
) (
   input  logic              tx_clk,
   input  logic              rx_clk,
   input  logic              rst_n,
   input  logic              gig_mode,
   input  logic [BYTE_W-1:0] mac_txd,
   input  logic              mac_tx_en,
   input  logic              mac_tx_er,
   output logic [NIB_W-1:0]  rgmii_txd,
   output logic              rgmii_tx_ctl,
   input  logic [NIB_W-1:0]  rgmii_rxd,
   input  logic              rgmii_rx_ctl,
   output logic [BYTE_W-1:0] mac_rxd,
   output logic              mac_rx_dv,
   output logic              mac_rx_er,
   output logic              link_up,
   output logic [1:0]        link_speed,
   output logic              full_duplex
);

   if (NIB_W < STAT_MIN_W) begin : g_bad_width
      $error("rgmii_bridge: NIB_W must be at least 4 to carry the status field");
   end

   logic [NIB_W-1:0] pair_nib;
   logic             pair_idle;
   lnk_stat_t        stat;

   rgb_tx_ddr #(.NIB_W(NIB_W)) u_tx (
      .clk   (tx_clk),
      .rst_n (rst_n),
      .gig   (gig_mode),
      .d     (mac_txd),
      .en    (mac_tx_en),
      .er    (mac_tx_er),
      .q     (rgmii_txd),
      .ctl   (rgmii_tx_ctl)
   );

   rgb_rx_ddr #(.NIB_W(NIB_W)) u_rx (
      .clk       (rx_clk),
      .rst_n     (rst_n),
      .gig       (gig_mode),
      .pin_d     (rgmii_rxd),
      .pin_ctl   (rgmii_rx_ctl),
      .rx_byte   (mac_rxd),
      .rx_dv     (mac_rx_dv),
      .rx_er     (mac_rx_er),
      .pair_nib  (pair_nib),
      .pair_idle (pair_idle)
   );

   rgb_inband_stat #(.NIB_W(NIB_W)) u_stat (
      .clk   (rx_clk),
      .rst_n (rst_n),
      .idle  (pair_idle),
      .nib   (pair_nib),
      .stat  (stat)
   );

   assign link_up     = stat.link;
   assign link_speed  = stat.speed;
   assign full_duplex = stat.fdx;

endmodule

// File: rtl/rgb_bridge_chk.sv
module rgb_bridge_chk #(
   parameter int NIB_W = 4
) (
   input logic             rx_clk,
   input logic             rst_n,
   input logic             gig_mode,
   input logic [NIB_W-1:0] rxd_hi,
   input logic             mac_rx_dv,
   input logic             mac_rx_er,
   input logic             link_up,
   input logic [1:0]       link_speed,
   input logic             full_duplex
);

   AST_RX_HI_ZERO: assert property (@(posedge rx_clk) disable iff (!rst_n)
      !$past(gig_mode) |-> (rxd_hi == '0)); // R5

   AST_LINK_RISE_IDLE: assert property (@(posedge rx_clk) disable iff (!rst_n)
      $rose(link_up) |-> (!mac_rx_dv && !mac_rx_er)); // R6

   AST_STAT_HOLD: assert property (@(posedge rx_clk) disable iff (!rst_n)
      (mac_rx_dv || mac_rx_er) |-> ($stable(link_up) && $stable(link_speed) && $stable(full_duplex))); // R7

   AST_SPEED_LEGAL: assert property (@(posedge rx_clk) disable iff (!rst_n)
      link_speed != 2'b11); // R8

endmodule

bind rgmii_bridge rgb_bridge_chk #(.NIB_W(NIB_W)) u_chk (
   .rx_clk      (rx_clk),
   .rst_n       (rst_n),
   .gig_mode    (gig_mode),
   .rxd_hi      (mac_rxd[2*NIB_W-1:NIB_W]),
   .mac_rx_dv   (mac_rx_dv),
   .mac_rx_er   (mac_rx_er),
   .link_up     (link_up),
   .link_speed  (link_speed),
   .full_duplex (full_duplex)
);

// File: tb/rgmii_bridge_bench.sv
module rgmii_bridge_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       gig_mode = 1'b1;
   logic [7:0] mac_txd = '0;
   logic       mac_tx_en = 1'b0;
   logic       mac_tx_er = 1'b0;
   logic [3:0] rgmii_txd;
   logic       rgmii_tx_ctl;
   logic [3:0] rgmii_rxd = '0;
   logic       rgmii_rx_ctl = 1'b0;
   logic [7:0] mac_rxd;
   logic       mac_rx_dv;
   logic       mac_rx_er;
   logic       link_up;
   logic [1:0] link_speed;
   logic       full_duplex;

   int checks = 0;
   int fails  = 0;

   logic       m_link = 1'b0;
   logic [1:0] m_spd  = 2'b00;
   logic       m_fdx  = 1'b0;

   always #4 clk = ~clk;

   rgmii_bridge u_rgmii_bridge (
      .tx_clk       (clk),
      .rx_clk       (clk),
      .rst_n        (rst_n),
      .gig_mode     (gig_mode),
      .mac_txd      (mac_txd),
      .mac_tx_en    (mac_tx_en),
      .mac_tx_er    (mac_tx_er),
      .rgmii_txd    (rgmii_txd),
      .rgmii_tx_ctl (rgmii_tx_ctl),
      .rgmii_rxd    (rgmii_rxd),
      .rgmii_rx_ctl (rgmii_rx_ctl),
      .mac_rxd      (mac_rxd),
      .mac_rx_dv    (mac_rx_dv),
      .mac_rx_er    (mac_rx_er),
      .link_up      (link_up),
      .link_speed   (link_speed),
      .full_duplex  (full_duplex)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Idle status nibble: bit0 link, bits2:1 speed (11 ignored), bit3 duplex
   function automatic void model_stat(input logic [3:0] n);
      if (n[2:1] != 2'b11) begin
         m_link = n[0];
         m_spd  = n[2:1];
         m_fdx  = n[3];
      end
   endfunction

   task automatic tx_byte(input logic [7:0] d, input logic e, input logic x);
      string req;
      req = gig_mode ? "R2" : "R3";
      @(negedge clk); #1;
      mac_txd = d; mac_tx_en = e; mac_tx_er = x;
      @(posedge clk); #2;
      chk(req, "tx high-phase nibble", rgmii_txd, d[3:0]);
      chk(req, "tx high-phase ctl", rgmii_tx_ctl, e);
      @(negedge clk); #1;
      chk(req, "tx low-phase nibble", rgmii_txd, gig_mode ? d[7:4] : d[3:0]);
      chk(req, "tx low-phase ctl", rgmii_tx_ctl, e ^ x);
   endtask

   task automatic rx_pair(input logic [3:0] r, input logic rc, input logic [3:0] f, input logic fc);
      string dreq;
      string sreq;
      dreq = gig_mode ? "R4" : "R5";
      if (rc || fc) sreq = "R7";
      else if (r[2:1] == 2'b11) sreq = "R8";
      else sreq = "R6";
      @(negedge clk); #2;
      rgmii_rxd = r; rgmii_rx_ctl = rc;
      @(posedge clk); #1;
      rgmii_rxd = f; rgmii_rx_ctl = fc;
      @(negedge clk); #1;
      rgmii_rxd = r; rgmii_rx_ctl = rc;
      @(posedge clk); #2;
      if (!rc && !fc) model_stat(r);
      chk(dreq, "rx byte", mac_rxd, gig_mode ? {f, r} : {4'h0, r});
      chk(dreq, "rx dv", mac_rx_dv, rc);
      chk(dreq, "rx er", mac_rx_er, rc ^ fc);
      chk(sreq, "link up", link_up, m_link);
      chk(sreq, "link speed", link_speed, m_spd);
      chk(sreq, "duplex", full_duplex, m_fdx);
      // Lines now rest on (r, rc) in both halves; decoded as idle if rc is low
      if (!rc) model_stat(r);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      mac_txd = 8'hA5; mac_tx_en = 1'b1; mac_tx_er = 1'b1;
      rgmii_rxd = 4'hF; rgmii_rx_ctl = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1", "reset tx nibble high", rgmii_txd, 4'h0);
      chk("R1", "reset tx ctl high", rgmii_tx_ctl, 1'b0);
      chk("R1", "reset rx byte", mac_rxd, 8'h00);
      chk("R1", "reset rx dv", mac_rx_dv, 1'b0);
      chk("R1", "reset rx er", mac_rx_er, 1'b0);
      chk("R1", "reset link", link_up, 1'b0);
      chk("R1", "reset speed", link_speed, 2'b00);
      chk("R1", "reset duplex", full_duplex, 1'b0);
      @(negedge clk); #1;
      chk("R1", "reset tx nibble low", rgmii_txd, 4'h0);
      chk("R1", "reset tx ctl low", rgmii_tx_ctl, 1'b0);
      mac_txd = '0; mac_tx_en = 1'b0; mac_tx_er = 1'b0;
      rgmii_rxd = '0;
      rst_n = 1'b1;

      // Gigabit then nibble mode: every byte with every enable/error pair
      gig_mode = 1'b1;
      for (int v = 0; v < 1024; v++) tx_byte(v[7:0], v[8], v[9]);
      gig_mode = 1'b0;
      for (int v = 0; v < 1024; v++) tx_byte(v[7:0], v[8], v[9]);

      // Receive: all nibble pairs with all control pairs, both modes
      gig_mode = 1'b1;
      rx_pair(4'h0, 1'b0, 4'h0, 1'b0);
      for (int v = 0; v < 1024; v++) rx_pair(v[3:0], v[8], v[7:4], v[9]);
      gig_mode = 1'b0;
      rx_pair(4'h0, 1'b0, 4'h0, 1'b0);
      for (int v = 0; v < 1024; v++) rx_pair(v[3:0], v[8], v[7:4], v[9]);

      // Directed: status set, then a frame and a reserved code must not move it
      rx_pair(4'b1101, 1'b0, 4'b1101, 1'b0);
      chk("R6", "directed link", link_up, 1'b1);
      chk("R6", "directed speed", link_speed, 2'b10);
      chk("R6", "directed duplex", full_duplex, 1'b1);
      rx_pair(4'b0000, 1'b1, 4'b0000, 1'b1);
      chk("R7", "held speed in frame", link_speed, 2'b10);
      rx_pair(4'b0110, 1'b0, 4'b0110, 1'b0);
      chk("R8", "reserved speed ignored", link_speed, 2'b10);
      chk("R8", "reserved link ignored", link_up, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule